// File: doc/BRIEF.md
# UART FIFO Interrupt State Unit

This unit holds the interrupt state of a serial port's transmit and receive queues. It does not store queue data. It counts how full each queue is, from push and pop strobes. By default the transmit queue holds 32 entries and the receive queue holds 64. A control register sets two 3-bit level codes, and each code is decoded into a fill threshold.

Three interrupt sources are level conditions recomputed from the counts every cycle:

- transmit below its threshold;
- receive at or above its threshold;
- transmit empty.

Writing ones to the state register cannot clear these three while their condition still holds. A fourth source, receive overflow, is an event. It latches and stays set until software clears it with a write of one. The readable state is the level conditions merged with the latched event. Each output line is that state masked by an enable register.

Software reaches the unit through a small register port: a 2-bit address, a write strobe and 8-bit write and read data. The read data is combinational from the address. A control write can also empty either queue's count.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The TX count rises by one on `txPush` and falls by one on `txPop`. A push while the count is 32 is ignored, a pop while it is 0 is ignored, and an accepted push and pop in the same cycle leave the count unchanged. `txCount` shows the value one cycle after the strobe.
- R2: The RX count follows the same rules with a limit of 64. Bytes pushed while it is full are dropped.
- R3: State bit 3 (RX overflow) is set the cycle after `rxPush` arrives while the RX count is 64. It stays set until a write to address 0 with data bit 3 set. If that write and a new overflow happen in the same cycle, the bit stays set.
- R4: State bit 2 (TX empty) is 1 exactly when the TX count is 0. A write to address 0 does not change it.
- R5: State bit 0 (TX watermark) is 1 when the TX count is below min(2^t, 16), where t is control bits [7:5]. A write to address 0 does not change it.
- R6: State bit 1 (RX watermark) is 1 when the RX count is at least min(2^r, 62), where r is control bits [4:2]. When r is 7 the bit is always 0.
- R7: A write to address 2 loads both level codes. Data bit 0 zeroes the RX count and data bit 1 zeroes the TX count, and both override a push or pop in the same cycle. Reading address 2 returns {t, r, 2'b00}.
- R8: `irq[i]` equals state bit i ANDed with enable bit i. The enable register is bits [3:0] of address 1.
- R9: After reset both counts, both level codes, the enables and the overflow bit are 0. The state therefore reads 8'h05 and `irq` is 0.
- R10: `regRdata` returns the state at address 0, the enables at address 1 and the level codes at address 2. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` |
| txPush | input | 1 | TX queue push strobe |
| txPop | input | 1 | TX queue pop strobe |
| rxPush | input | 1 | RX queue push strobe |
| rxPop | input | 1 | RX queue pop strobe |
| txCount | output | 6 | TX occupancy |
| rxCount | output | 7 | RX occupancy |
| irq | output | 4 | Masked interrupt lines |

## Verification
Every cycle, the assertions check that:

- the counts stay within their depths;
- a queue clear lands one cycle later;
- a push into a full queue leaves the count unchanged;
- the overflow bit latches and holds until it is cleared;
- level code 7 keeps the RX watermark low;
- zeroing the enables silences every line.

The exact watermark thresholds, their saturation, and the fact that a clear write has no effect on level conditions are shown only by the bench. It compares every bit of the read port against its own model, under random traffic and directed fill, drain and overflow runs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_N = 4;
  localparam int LVL_W = 3;
  localparam int IDX_TXWM  = 0;
  localparam int IDX_RXWM  = 1;
  localparam int IDX_TXEMP = 2;
  localparam int IDX_RXOVF = 3;

  localparam logic [1:0] ADDR_STATE  = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_FCTRL  = 2'd2;

  localparam logic [LVL_W-1:0] RX_OFF_CODE = '1;

  typedef struct packed {
    logic             txClr;
    logic             rxClr;
    logic             lvlLoad;
    logic [LVL_W-1:0] txLvlNew;
    logic [LVL_W-1:0] rxLvlNew;
  } fifoCmd_t;
endpackage

// File: rtl/uart_occ_cnt.sv
module uart_occ_cnt #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count
);
  logic isFull, isEmpty, pushOk, popOk;

  assign isFull  = (count == CW'(DEPTH));
  assign isEmpty = (count == '0);
  assign pushOk  = push && !isFull;
  assign popOk   = pop && !isEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  count <= '0;
    else if (clr)               count <= '0;
    else if (pushOk && !popOk)  count <= count + 1'b1;
    else if (popOk && !pushOk)  count <= count - 1'b1;
  end

  // R1 R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R7
  occ_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));

  // R2
  occ_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && push && !pop && !clr) |=> $stable(count));
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmd_t         cmd,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  output logic [TXC_W-1:0] txCount,
  output logic [RXC_W-1:0] rxCount,
  output logic [LVL_W-1:0] txLvl,
  output logic [LVL_W-1:0] rxLvl,
  output logic             rxFull,
  output logic [2:0]       statusBits
);
  localparam int TX_CAP = TX_DEPTH / 2;
  localparam int RX_CAP = RX_DEPTH - 2;

  logic [TXC_W-1:0] txThr;
  logic [RXC_W-1:0] rxThr;
  int txPow, rxPow;

  uart_occ_cnt #(.DEPTH(TX_DEPTH)) uTxCnt (
    .clk(clk), .rstN(rstN), .clr(cmd.txClr),
    .push(txPush), .pop(txPop), .count(txCount));

  uart_occ_cnt #(.DEPTH(RX_DEPTH)) uRxCnt (
    .clk(clk), .rstN(rstN), .clr(cmd.rxClr),
    .push(rxPush), .pop(rxPop), .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLvl <= '0;
      rxLvl <= '0;
    end else if (cmd.lvlLoad) begin
      txLvl <= cmd.txLvlNew;
      rxLvl <= cmd.rxLvlNew;
    end
  end

  always_comb begin
    txPow = 32'd1 << txLvl;
    rxPow = 32'd1 << rxLvl;
    txThr = (txPow > TX_CAP) ? TXC_W'(TX_CAP) : TXC_W'(txPow);
    rxThr = (rxPow > RX_CAP) ? RXC_W'(RX_CAP) : RXC_W'(rxPow);
  end

  assign rxFull = (rxCount == RXC_W'(RX_DEPTH));
  assign statusBits[IDX_TXWM]  = (txCount < txThr);
  assign statusBits[IDX_RXWM]  = (rxLvl != RX_OFF_CODE) && (rxCount >= rxThr);
  assign statusBits[IDX_TXEMP] = (txCount == '0);
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWdata,
  input  logic             rxPush,
  input  logic             rxFull,
  input  logic [2:0]       statusBits,
  input  logic [LVL_W-1:0] txLvl,
  input  logic [LVL_W-1:0] rxLvl,
  output fifoCmd_t         cmd,
  output logic [7:0]       regRdata,
  output logic [IRQ_N-1:0] irq
);
  logic             ctrlWr, stateWr, enWr, ovfEvent, ovfQ;
  logic [IRQ_N-1:0] enQ, intrState;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_FCTRL);
  assign stateWr  = regWrEn && (regAddr == ADDR_STATE);
  assign enWr     = regWrEn && (regAddr == ADDR_ENABLE);
  assign ovfEvent = rxPush && rxFull;

  always_comb begin
    cmd.rxClr    = ctrlWr && regWdata[0];
    cmd.txClr    = ctrlWr && regWdata[1];
    cmd.lvlLoad  = ctrlWr;
    cmd.rxLvlNew = regWdata[4:2];
    cmd.txLvlNew = regWdata[7:5];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
      enQ  <= '0;
    end else begin
      if (ovfEvent)                           ovfQ <= 1'b1;
      else if (stateWr && regWdata[IDX_RXOVF]) ovfQ <= 1'b0;
      if (enWr) enQ <= regWdata[IRQ_N-1:0];
    end
  end

  assign intrState = {ovfQ, statusBits};
  assign irq       = intrState & enQ;

  always_comb begin
    unique case (regAddr)
      ADDR_STATE:  regRdata = {4'b0, intrState};
      ADDR_ENABLE: regRdata = {4'b0, enQ};
      ADDR_FCTRL:  regRdata = {txLvl, rxLvl, 2'b00};
      default:     regRdata = 8'h00;
    endcase
  end

  // R3
  ovf_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> intrState[IDX_RXOVF]);

  // R3
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intrState[IDX_RXOVF] && !(stateWr && regWdata[IDX_RXOVF]))
      |=> intrState[IDX_RXOVF]);

  // R6
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLvl == RX_OFF_CODE) |-> !intrState[IDX_RXWM]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && regWdata[IRQ_N-1:0] == '0) |=> (irq == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  output logic [TXC_W-1:0] txCount,
  output logic [RXC_W-1:0] rxCount,
  output logic [IRQ_N-1:0] irq
);
  fifoCmd_t         cmd;
  logic [LVL_W-1:0] txLvl, rxLvl;
  logic             rxFull;
  logic [2:0]       statusBits;

  uart_irq_dp #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .txCount(txCount), .rxCount(rxCount), .txLvl(txLvl), .rxLvl(rxLvl),
    .rxFull(rxFull), .statusBits(statusBits));

  uart_irq_ctl uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .rxPush(rxPush), .rxFull(rxFull),
    .statusBits(statusBits), .txLvl(txLvl), .rxLvl(rxLvl),
    .cmd(cmd), .regRdata(regRdata), .irq(irq));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [5:0] txCount;
  logic [6:0] rxCount;
  logic [3:0] irq;

  int errs = 0, checks = 0;
  bit done = 0;
  int mTx = 0, mRx = 0;
  logic [2:0] mTxL = 0, mRxL = 0;
  logic [3:0] mEn = 0;
  logic mOvf = 0;

  uart_irq_ctrl dut (.*);

  always #5 clk = ~clk;

  function automatic int txThr(logic [2:0] c);
    return ((1 << c) > 16) ? 16 : (1 << c);
  endfunction

  function automatic int rxThr(logic [2:0] c);
    return ((1 << c) > 62) ? 62 : (1 << c);
  endfunction

  function automatic logic [3:0] expState();
    logic [3:0] s;
    s[0] = (mTx < txThr(mTxL));
    s[1] = (mRxL != 3'd7) && (mRx >= rxThr(mRxL));
    s[2] = (mTx == 0);
    s[3] = mOvf;
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [3:0] s;
    s = expState();
    chk(txCount == mTx, "R1 txCount", txCount, mTx);
    chk(rxCount == mRx, "R2 rxCount", rxCount, mRx);
    chk(irq == (s & mEn), "R8 irq", irq, s & mEn);
    case (regAddr)
      2'd0: begin
        chk(regRdata[0] == s[0], "R5 txWatermark", regRdata[0], s[0]);
        chk(regRdata[1] == s[1], "R6 rxWatermark", regRdata[1], s[1]);
        chk(regRdata[2] == s[2], "R4 txEmpty", regRdata[2], s[2]);
        chk(regRdata[3] == s[3], "R3 rxOverflow", regRdata[3], s[3]);
      end
      2'd1: chk(regRdata == {4'b0, mEn}, "R10 enable read", regRdata, mEn);
      2'd2: chk(regRdata == {mTxL, mRxL, 2'b00}, "R7 level read", regRdata, {mTxL, mRxL, 2'b00});
      default: chk(regRdata == 8'h00, "R10 unused read", regRdata, 0);
    endcase
  endtask

  task automatic cyc(logic [1:0] a, logic we, logic [7:0] wd,
                     logic tp, logic tpo, logic rp, logic rpo);
    bit ev, ctrl;
    @(negedge clk);
    regAddr = a; regWrEn = we; regWdata = wd;
    txPush = tp; txPop = tpo; rxPush = rp; rxPop = rpo;
    @(posedge clk);
    ev = rp && (mRx == 64);
    ctrl = we && (a == 2'd2);
    if (ctrl && wd[1]) mTx = 0;
    else mTx += int'(tp && mTx < 32) - int'(tpo && mTx > 0);
    if (ctrl && wd[0]) mRx = 0;
    else mRx += int'(rp && mRx < 64) - int'(rpo && mRx > 0);
    if (ev) mOvf = 1;
    else if (we && a == 2'd0 && wd[3]) mOvf = 0;
    if (we && a == 2'd1) mEn = wd[3:0];
    if (ctrl) begin mRxL = wd[4:2]; mTxL = wd[7:5]; end
    #2;
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (4) @(posedge clk);
    #2;
    // R9 reset state
    chk(regRdata == 8'h05, "R9 reset state", regRdata, 8'h05);
    chk(irq == 4'h0, "R9 reset irq", irq, 0);
    chk(txCount == 0 && rxCount == 0, "R9 reset counts", {txCount, rxCount}, 0);
    @(negedge clk); rstN = 1'b1;
    cyc(2'd0, 0, 0, 0, 0, 0, 0);

    // R8 enable all; R6 code 7 disables rx watermark while RX fills
    cyc(2'd1, 1, 8'h0F, 0, 0, 0, 0);
    cyc(2'd2, 1, 8'h1C, 0, 0, 0, 0);
    for (int i = 0; i < 66; i++) cyc(2'd0, 0, 0, 0, 0, 1, 0);
    // R3 clear while overflow event repeats: stays set
    cyc(2'd0, 1, 8'h08, 0, 0, 1, 0);
    // R3 clear with no event; R4/R5 clear write has no effect
    cyc(2'd0, 1, 8'h0F, 0, 0, 0, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 0);
    // R6 saturation at 62 with code 6
    cyc(2'd2, 1, 8'h18, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(2'd0, 0, 0, 0, 0, 0, 1);
    // R5 TX fill with code 7 (threshold 16)
    cyc(2'd2, 1, 8'hE0, 0, 0, 0, 0);
    for (int i = 0; i < 34; i++) cyc(2'd0, 0, 0, 1, (i == 20), 0, 0);
    for (int i = 0; i < 18; i++) cyc(2'd0, 0, 0, 0, 1, 0, 0);
    // R7 clears beat same-cycle push/pop
    cyc(2'd2, 1, 8'h43, 1, 1, 1, 1);
    cyc(2'd2, 0, 0, 0, 1, 0, 1);
    cyc(2'd3, 0, 0, 0, 0, 0, 0);

    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        logic [1:0] a;
        logic we;
        logic [7:0] wd;
        int pp;
        pp = (ph % 3 == 0) ? 70 : (ph % 3 == 1) ? 30 : 50;
        a = 2'($urandom % 4);
        we = ($urandom % 12) == 0;
        wd = 8'($urandom);
        if (a == 2'd2 && ($urandom % 8) != 0) wd[1:0] = 2'b00;
        cyc(a, we, wd, ($urandom % 100) < pp, ($urandom % 100) >= pp,
            ($urandom % 100) < pp, ($urandom % 100) >= pp);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule